// File: doc/BRIEF.md
# Self-Timed Slow-Port Bus Controller

This block is the master for a slow byte-wide peripheral, such as a boot PROM, attached to a shared 8-bit address/data bus. The host hands it one request at a time through a valid/ready port. Each request carries a 25-bit byte address, a write byte, a read/write bit and a self-timed enable. The controller puts the upper address bits on the shared bus in three latched byte phases. The two lowest address bits go on their own pins. It then opens chip select, waits a programmed setup time, asserts the read or write strobe, and closes the access with a programmed hold time before it returns a response.

Three configuration fields set the setup, strobe and hold durations. In fixed-timing mode the strobe lasts for the programmed pulse width and the acknowledge pin is ignored. In self-timed mode the device's active-low acknowledge ends the strobe, and a watchdog bounds the wait. If the acknowledge has not arrived after 256 strobe cycles, the access is aborted. In that case an interrupt pulse is raised, the failing address is recorded, and the host gets an error response in place of data.

Top module: `slowport_ctrl`

## Requirements
- R1: Cycles 0, 1 and 2 after a request is accepted are address phases. In each of them the latch enable is low for one cycle and the bus is driven with, in order, {1'b0, addr[24:18]}, addr[17:10] and addr[9:2]. Chip select is high during these phases.
- R2: While a transaction is in progress, sp_a carries addr[1:0]. It is 0 when the controller is idle.
- R3: From cycle 3 until the response, the bus is driven only for writes, and it then carries the write byte. A read leaves the bus undriven (sp_ad_oe low).
- R4: Cycle 3 is a turnaround cycle with chip select low. It is followed by cfg_setup+1 setup cycles with chip select low and both strobes high. In fixed-timing mode the strobe (read or write, by request type) then stays low for cfg_pulse+1 cycles, whatever the acknowledge pin does.
- R5: In self-timed mode, the acknowledge passes through a two-stage synchronizer. The strobe ends at the first clock edge at which the synchronized acknowledge is low, and read data is sampled at that edge. With setup 4, pulse 0, hold 2 and acknowledge low from the first strobe cycle, read data is sampled at the 12th clock edge after the accepting edge.
- R6: In self-timed mode, if no synchronized acknowledge is seen, the strobe ends at the 256th edge after it started, and the response carries error = 1 with data 0. An acknowledge seen at that same edge wins, and the response is then normal.
- R7: A time-out produces a one-cycle irq pulse in the first hold cycle, and tmo_addr takes the request's address.
- R8: After the strobe, all control pins are high for cfg_hold+1 cycles before the response is offered.
- R9: rsp_valid stays high with stable data and error until rsp_ready. req_ready is high only while idle, and a request held valid during a transaction is taken in the first idle cycle.
- R10: After reset the controller is idle: all control pins high, bus undriven, req_ready high, rsp_valid, irq and tmo_addr zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_setup | input | 4 | Setup length minus one |
| cfg_pulse | input | 4 | Fixed strobe length minus one |
| cfg_hold | input | 4 | Hold length minus one |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_addr | input | 25 | Byte address |
| req_wdata | input | 8 | Write byte |
| req_write | input | 1 | 1 = write, 0 = read |
| req_selftimed | input | 1 | 1 = acknowledge ends strobe |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Host takes the response |
| rsp_rdata | output | 8 | Read byte (0 for writes and time-outs) |
| rsp_error | output | 1 | Access timed out |
| irq | output | 1 | One-cycle time-out interrupt |
| tmo_addr | output | 25 | Address of the last timed-out access |
| sp_ale_n | output | 1 | Address latch enable, active low |
| sp_cs_n | output | 1 | Chip select, active low |
| sp_rd_n | output | 1 | Read strobe, active low |
| sp_wr_n | output | 1 | Write strobe, active low |
| sp_a | output | 2 | Low address bits |
| sp_ad_o | output | 8 | Bus output value |
| sp_ad_oe | output | 1 | Bus output enable |
| sp_ad_i | input | 8 | Bus input value |
| sp_ack_n | input | 1 | Device acknowledge, active low |

## Verification
The hardest case to reach is the edge of the watchdog window, where a late acknowledge and the time-out land on the same clock edge. The bench's device model asserts acknowledge a chosen number of strobe cycles after the strobe falls. Delays of 253 and 254 cycles put the synchronized acknowledge exactly on, and one cycle past, the 256th edge, so both sides of that boundary are covered. The same device model holds acknowledge low through a fixed-timing access to show that it is ignored. A request kept valid during a busy transaction exercises back-to-back acceptance.

// File: rtl/sp_pkg.sv
package sp_pkg;

    localparam int ADDR_W = 25;
    localparam int DATA_W = 8;
    localparam int TIME_W = 4;

    typedef enum logic [3:0] {
        ST_IDLE, ST_ADR0, ST_ADR1, ST_ADR2, ST_TURN,
        ST_SETUP, ST_STROBE, ST_HOLD, ST_RESP
    } sp_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              write;
        logic              selftimed;
    } sp_req_t;

    // Byte placed on the shared bus during address phase idx (0..2).
    function automatic logic [DATA_W-1:0] addr_byte(input logic [ADDR_W-1:0] a,
                                                    input logic [1:0] idx);
        case (idx)
            2'd0:    return {1'b0, a[24:18]};
            2'd1:    return a[17:10];
            default: return a[9:2];
        endcase
    endfunction

endpackage

// File: rtl/sp_phase_timer.sv
module sp_phase_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (load)          cnt_q <= load_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - W'(1);
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/sp_ack_sync.sv
module sp_ack_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ack_n_in,
    output logic ack_n_sync
);
    logic [STAGES-1:0] pipe_q;

    always_ff @(posedge clk) begin
        if (rst) pipe_q <= '1;
        else     pipe_q <= {pipe_q[STAGES-2:0], ack_n_in};
    end

    assign ack_n_sync = pipe_q[STAGES-1];
endmodule

// File: rtl/sp_watchdog.sv
module sp_watchdog #(
    parameter int LIMIT = 256,
    localparam int CW = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic run,
    output logic expired
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                    cnt_q <= '0;
        else if (arm)               cnt_q <= CW'(LIMIT);
        else if (run && cnt_q != '0) cnt_q <= cnt_q - CW'(1);
    end

    assign expired = run && (cnt_q == CW'(1));

    // R6: while counting, the window is never already exhausted
    a_r6_window_live: assert property (@(posedge clk) disable iff (rst)
        run |-> cnt_q != '0);
endmodule

// File: rtl/slowport_ctrl.sv
module slowport_ctrl
    import sp_pkg::*;
#(
    parameter int TIMEOUT = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TIME_W-1:0] cfg_setup,
    input  logic [TIME_W-1:0] cfg_pulse,
    input  logic [TIME_W-1:0] cfg_hold,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_write,
    input  logic              req_selftimed,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_error,
    output logic              irq,
    output logic [ADDR_W-1:0] tmo_addr,
    output logic              sp_ale_n,
    output logic              sp_cs_n,
    output logic              sp_rd_n,
    output logic              sp_wr_n,
    output logic [1:0]        sp_a,
    output logic [DATA_W-1:0] sp_ad_o,
    output logic              sp_ad_oe,
    input  logic [DATA_W-1:0] sp_ad_i,
    input  logic              sp_ack_n
);
    sp_state_e          st_q, st_d;
    sp_req_t            req_q;
    logic               tm_load, tm_zero;
    logic [TIME_W-1:0]  tm_val;
    logic               wd_arm, wd_run, wd_expired;
    logic               ack_n_s;
    logic               cap_ok, cap_tmo;
    logic [DATA_W-1:0]  rdata_q;
    logic               err_q, irq_q;
    logic [ADDR_W-1:0]  tmo_addr_q;
    logic               in_addr, in_access;

    sp_phase_timer #(.W(TIME_W)) u_timer (
        .clk(clk), .rst(rst), .load(tm_load), .load_val(tm_val), .zero(tm_zero));

    sp_ack_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .ack_n_in(sp_ack_n), .ack_n_sync(ack_n_s));

    sp_watchdog #(.LIMIT(TIMEOUT)) u_wd (
        .clk(clk), .rst(rst), .arm(wd_arm), .run(wd_run), .expired(wd_expired));

    assign wd_run = (st_q == ST_STROBE) && req_q.selftimed;

    always_comb begin
        st_d    = st_q;
        tm_load = 1'b0;
        tm_val  = '0;
        wd_arm  = 1'b0;
        cap_ok  = 1'b0;
        cap_tmo = 1'b0;
        case (st_q)
            ST_IDLE:  if (req_valid) st_d = ST_ADR0;
            ST_ADR0:  st_d = ST_ADR1;
            ST_ADR1:  st_d = ST_ADR2;
            ST_ADR2:  st_d = ST_TURN;
            ST_TURN: begin
                st_d = ST_SETUP; tm_load = 1'b1; tm_val = cfg_setup;
            end
            ST_SETUP: if (tm_zero) begin
                st_d = ST_STROBE; tm_load = 1'b1; tm_val = cfg_pulse; wd_arm = 1'b1;
            end
            ST_STROBE: begin
                if (req_q.selftimed) begin
                    if (!ack_n_s)        cap_ok  = 1'b1;
                    else if (wd_expired) cap_tmo = 1'b1;
                end else if (tm_zero) begin
                    cap_ok = 1'b1;
                end
                if (cap_ok || cap_tmo) begin
                    st_d = ST_HOLD; tm_load = 1'b1; tm_val = cfg_hold;
                end
            end
            ST_HOLD:  if (tm_zero) st_d = ST_RESP;
            ST_RESP:  if (rsp_ready) st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            req_q      <= '0;
            rdata_q    <= '0;
            err_q      <= 1'b0;
            irq_q      <= 1'b0;
            tmo_addr_q <= '0;
        end else begin
            st_q  <= st_d;
            irq_q <= 1'b0;
            if (st_q == ST_IDLE && req_valid) begin
                req_q <= '{addr: req_addr, wdata: req_wdata,
                           write: req_write, selftimed: req_selftimed};
            end
            if (cap_ok) begin
                rdata_q <= req_q.write ? '0 : sp_ad_i;
                err_q   <= 1'b0;
            end else if (cap_tmo) begin
                rdata_q    <= '0;
                err_q      <= 1'b1;
                irq_q      <= 1'b1;
                tmo_addr_q <= req_q.addr;
            end
        end
    end

    assign in_addr   = (st_q == ST_ADR0) || (st_q == ST_ADR1) || (st_q == ST_ADR2);
    assign in_access = (st_q == ST_TURN) || (st_q == ST_SETUP) || (st_q == ST_STROBE);

    always_comb begin
        sp_ad_o  = '0;
        sp_ad_oe = 1'b0;
        if (in_addr) begin
            sp_ad_oe = 1'b1;
            sp_ad_o  = addr_byte(req_q.addr, (st_q == ST_ADR0) ? 2'd0 :
                                             (st_q == ST_ADR1) ? 2'd1 : 2'd2);
        end else if (req_q.write && (in_access || st_q == ST_HOLD)) begin
            sp_ad_oe = 1'b1;
            sp_ad_o  = req_q.wdata;
        end
    end

    assign sp_ale_n  = !in_addr;
    assign sp_cs_n   = !in_access;
    assign sp_rd_n   = !((st_q == ST_STROBE) && !req_q.write);
    assign sp_wr_n   = !((st_q == ST_STROBE) &&  req_q.write);
    assign sp_a      = (st_q == ST_IDLE) ? 2'b00 : req_q.addr[1:0];
    assign req_ready = (st_q == ST_IDLE);
    assign rsp_valid = (st_q == ST_RESP);
    assign rsp_rdata = rdata_q;
    assign rsp_error = err_q;
    assign irq       = irq_q;
    assign tmo_addr  = tmo_addr_q;

    // R1: address latch never overlaps chip select
    a_r1_ale_excl_cs: assert property (@(posedge clk) disable iff (rst)
        !sp_ale_n |-> sp_cs_n);
    // R3: the controller never drives the bus while the read strobe is low
    a_r3_no_drive_on_read: assert property (@(posedge clk) disable iff (rst)
        !sp_rd_n |-> !sp_ad_oe);
    // R7: interrupt lasts one cycle
    a_r7_irq_single: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);
    // R9: response held stable until taken
    a_r9_rsp_hold: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_error));
    // R9: accepting requests only with the device pins quiet
    a_r9_ready_quiet: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> sp_cs_n && sp_ale_n && sp_rd_n && sp_wr_n);
endmodule

// File: tb/slowport_ctrl_bench.sv
module slowport_ctrl_bench;
    localparam int TMO = 256;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  cfg_setup = 4'd4, cfg_pulse = 4'd0, cfg_hold = 4'd2;
    logic        req_valid = 1'b0, req_ready;
    logic [24:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_write = 1'b0, req_selftimed = 1'b0;
    logic        rsp_valid, rsp_ready = 1'b1, rsp_error, irq;
    logic [7:0]  rsp_rdata;
    logic [24:0] tmo_addr;
    logic        sp_ale_n, sp_cs_n, sp_rd_n, sp_wr_n, sp_ad_oe;
    logic [1:0]  sp_a;
    logic [7:0]  sp_ad_o, sp_ad_i = '0;
    logic        sp_ack_n = 1'b1;

    slowport_ctrl u_slowport_ctrl (
        .clk(clk), .rst(rst), .cfg_setup(cfg_setup), .cfg_pulse(cfg_pulse),
        .cfg_hold(cfg_hold), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_write(req_write),
        .req_selftimed(req_selftimed), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_rdata(rsp_rdata), .rsp_error(rsp_error), .irq(irq), .tmo_addr(tmo_addr),
        .sp_ale_n(sp_ale_n), .sp_cs_n(sp_cs_n), .sp_rd_n(sp_rd_n), .sp_wr_n(sp_wr_n),
        .sp_a(sp_a), .sp_ad_o(sp_ad_o), .sp_ad_oe(sp_ad_oe), .sp_ad_i(sp_ad_i),
        .sp_ack_n(sp_ack_n));

    always #10 clk = ~clk;   // 50 MHz

    int n_vec = 0, n_bad = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    bit          m_busy = 0, m_wr = 0, m_st = 0, m_tmo = 0, m_irq = 0, irq_nx;
    bit          m_a1 = 1, m_a2 = 1;
    int          m_t = 0, m_te = -1, ts, tn;
    logic [24:0] m_addr = '0, m_tmo_addr = '0;
    logic [7:0]  m_wd = '0, m_data = '0;

    always @(posedge clk) begin
        irq_nx = 0;
        if (rst) begin
            m_busy = 0; m_a1 = 1; m_a2 = 1; m_tmo = 0; m_data = '0; m_tmo_addr = '0;
        end else begin
            if (!m_busy) begin
                if (req_valid) begin
                    m_busy = 1; m_t = 0; m_te = -1;
                    m_addr = req_addr; m_wd = req_wdata; m_wr = req_write; m_st = req_selftimed;
                end
            end else begin
                ts = 5 + int'(cfg_setup);
                tn = m_t + 1;
                if (m_te < 0 && m_t >= ts) begin
                    if (!m_st) begin
                        if (tn == ts + int'(cfg_pulse) + 1) begin
                            m_te = tn; m_tmo = 0; m_data = m_wr ? 8'h00 : sp_ad_i;
                        end
                    end else if (!m_a2) begin
                        m_te = tn; m_tmo = 0; m_data = m_wr ? 8'h00 : sp_ad_i;
                    end else if (tn - ts == TMO) begin
                        m_te = tn; m_tmo = 1; m_data = 8'h00; irq_nx = 1; m_tmo_addr = m_addr;
                    end
                end else if (m_te >= 0 && m_t >= m_te + int'(cfg_hold) + 1 && rsp_ready) begin
                    m_busy = 0;
                end
                m_t = tn;
            end
            m_a2 = m_a1; m_a1 = sp_ack_n;
        end
        m_irq = irq_nx;
    end

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        if (!rst) begin
            string tg;
            logic [3:0] e_ctl;
            logic e_oe, e_rsp;
            logic [7:0] e_ad;
            int s;
            s = 5 + int'(cfg_setup);
            e_ctl = 4'b1111; e_oe = 0; e_ad = '0; e_rsp = 0; tg = "R10";
            if (m_busy) begin
                if (m_t < 3) begin
                    e_ctl = 4'b0111; e_oe = 1; tg = "R1";
                    e_ad = (m_t == 0) ? {1'b0, m_addr[24:18]} : (m_t == 1) ? m_addr[17:10] : m_addr[9:2];
                end else if (m_t < s) begin
                    e_ctl = 4'b1011; e_oe = m_wr; e_ad = m_wd; tg = "R4";
                end else if (m_te < 0) begin
                    e_ctl = {2'b10, m_wr, !m_wr}; e_oe = m_wr; e_ad = m_wd; tg = m_st ? "R5" : "R4";
                end else if (m_t < m_te + int'(cfg_hold) + 1) begin
                    e_oe = m_wr; e_ad = m_wd; tg = "R8";
                end else begin
                    e_rsp = 1; tg = "R9";
                end
            end
            chk({sp_ale_n, sp_cs_n, sp_rd_n, sp_wr_n} === e_ctl, {tg, " ale/cs/rd/wr"},
                {sp_ale_n, sp_cs_n, sp_rd_n, sp_wr_n}, e_ctl);
            chk(sp_ad_oe === e_oe, "R3 bus enable", sp_ad_oe, e_oe);
            if (e_oe) chk(sp_ad_o === e_ad, (m_t < 3) ? "R1 bus byte" : "R3 write byte", sp_ad_o, e_ad);
            chk(sp_a === (m_busy ? m_addr[1:0] : 2'b00), "R2 low address", sp_a, m_busy ? m_addr[1:0] : 2'b00);
            chk(req_ready === !m_busy, "R9 req_ready", req_ready, !m_busy);
            chk(rsp_valid === e_rsp, "R9 rsp_valid", rsp_valid, e_rsp);
            if (e_rsp) begin
                chk(rsp_rdata === m_data, m_tmo ? "R6 rsp_rdata" : "R9 rsp_rdata", rsp_rdata, m_data);
                chk(rsp_error === m_tmo, m_tmo ? "R6 rsp_error" : "R9 rsp_error", rsp_error, m_tmo);
            end
            chk(irq === m_irq, "R7 irq", irq, m_irq);
            chk(tmo_addr === m_tmo_addr, "R7 tmo_addr", tmo_addr, m_tmo_addr);
        end
    end

    // ---------------- device model ----------------
    int ack_dly = -1;   // -1 never, -2 always low, else strobe cycles before ack
    int sc = 0;
    int cyc = 0;
    always @(negedge clk) begin
        cyc++;
        sp_ad_i <= 8'(cyc * 37 + 5);
        if (!sp_rd_n || !sp_wr_n) begin
            sp_ack_n <= !((ack_dly == -2) || (ack_dly >= 0 && sc >= ack_dly));
            sc++;
        end else begin
            sc = 0;
            sp_ack_n <= (ack_dly == -2) ? 1'b0 : 1'b1;
        end
    end

    // observed responses
    bit last_err = 0;
    always @(posedge clk) if (!rst && rsp_valid && rsp_ready) last_err = rsp_error;

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    task automatic wait_idle();
        while (!req_ready) @(negedge clk);
    endtask

    task automatic issue(input logic [24:0] a, input logic [7:0] d, input bit wr, input bit st);
        wait_idle();
        req_addr = a; req_wdata = d; req_write = wr; req_selftimed = st; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic run_txn(input logic [24:0] a, input logic [7:0] d, input bit wr, input bit st);
        issue(a, d, wr, st);
        wait_idle();
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(req_ready === 1'b1 && rsp_valid === 1'b0, "R10 reset handshake", {req_ready, rsp_valid}, 2'b10);
        chk({sp_ale_n, sp_cs_n, sp_rd_n, sp_wr_n, sp_ad_oe} === 5'b11110, "R10 reset pins",
            {sp_ale_n, sp_cs_n, sp_rd_n, sp_wr_n, sp_ad_oe}, 5'b11110);
        chk(irq === 1'b0 && tmo_addr === '0, "R10 reset irq/tmo", {irq, tmo_addr}, 0);
        rst = 1'b0;
        @(negedge clk);

        // R5: reference self-timed read, prompt ack -> strobe ends at edge 12
        begin
            int n;
            bit seen;
            ack_dly = 0;
            cfg_setup = 4'd4; cfg_pulse = 4'd0; cfg_hold = 4'd2;
            issue(25'h1AB_CDEF, 8'h00, 1'b0, 1'b1);
            n = 0; seen = 0;
            forever begin
                @(negedge clk); n++;
                if (!sp_rd_n) seen = 1;
                else if (seen) break;
            end
            chk(n == 12, "R5 sample edge", n, 12);
            wait_idle(); @(negedge clk);
        end

        // R5: self-timed write with delayed ack
        ack_dly = 5;
        run_txn(25'h0F0_F0F3, 8'hA5, 1'b1, 1'b1);

        // R4: fixed read, ack held low must be ignored
        ack_dly = -2;
        cfg_setup = 4'd0; cfg_pulse = 4'd3; cfg_hold = 4'd0;
        run_txn(25'h155_5552, 8'h00, 1'b0, 1'b0);

        // R4: fixed write with other timing
        cfg_setup = 4'd2; cfg_pulse = 4'd1; cfg_hold = 4'd1;
        run_txn(25'h0AA_AAA9, 8'h3C, 1'b1, 1'b0);

        // R6/R7: time-out on a read, ack never comes
        ack_dly = -1;
        cfg_setup = 4'd4; cfg_pulse = 4'd0; cfg_hold = 4'd2;
        run_txn(25'h123_4567, 8'h00, 1'b0, 1'b1);
        chk(last_err === 1'b1, "R6 error reported", last_err, 1);
        chk(tmo_addr === 25'h123_4567, "R7 recorded address", tmo_addr, 25'h123_4567);

        // R6: ack on the last watchdog edge wins
        ack_dly = 253;
        run_txn(25'h000_0101, 8'h00, 1'b0, 1'b1);
        chk(last_err === 1'b0, "R6 ack at limit", last_err, 0);

        // R6: ack one cycle late -> time-out on a write
        ack_dly = 254;
        run_txn(25'h1FF_FFFE, 8'h77, 1'b1, 1'b1);
        chk(last_err === 1'b1, "R6 ack past limit", last_err, 1);
        chk(tmo_addr === 25'h1FF_FFFE, "R7 second recorded address", tmo_addr, 25'h1FF_FFFE);

        // R9: read followed directly by write, request held valid while busy
        ack_dly = 1;
        wait_idle();
        req_addr = 25'h0C3_0C31; req_write = 1'b0; req_selftimed = 1'b1; req_valid = 1'b1;
        @(negedge clk);
        req_addr = 25'h13C_13C2; req_wdata = 8'h5A; req_write = 1'b1; req_selftimed = 1'b0;
        wait_idle();
        @(negedge clk);
        req_valid = 1'b0;
        wait_idle(); @(negedge clk);

        // R9: response stalled by host
        rsp_ready = 1'b0;
        issue(25'h0DE_AD03, 8'h00, 1'b0, 1'b1);
        while (!rsp_valid) @(negedge clk);
        repeat (5) @(negedge clk);
        chk(rsp_valid === 1'b1, "R9 response held", rsp_valid, 1);
        rsp_ready = 1'b1;
        wait_idle();
        repeat (3) @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule